// File: doc/BRIEF.md
# Flash Command Mode Controller

This block follows the command writes a host makes to a flash-style memory and keeps track of the operating mode they select. Each qualified write (`wr_valid_i` with an address and a data word) moves a sequencer through the unlock handshake and the command that follows it. The sequencer can enter read-array, autoselect, embedded program, embedded erase, erase-suspend or a defined error mode. The program and erase engines are outside the block. It starts them with one-cycle pulses, holds a suspended erase with a level, and learns the result from `op_done_i` and `op_fail_i`.

For every read, the controller picks the source of the returned word. The source is array data, status data, or the identification data of autoselect mode. While an erase is suspended, only reads that land in the suspended sector return status. A per-sector protect map blocks program and erase. A high-voltage indication on the reset pin (`hv_unprot_i`) lifts that protection while it is present. When it is removed, the map applies again.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After a synchronous reset, `mode_o` is 0 (read-array), `rd_src_o` is 0 (array), and `prog_start_o`, `erase_start_o` and `erase_hold_o` are low.
- R2: The unlock cycles are data 0xAA at low address 0x555, then 0x55 at 0x2AA. A following 0xA0 at 0x555 arms a program. The next write of any address and data raises `prog_start_o` for one cycle and sets `op_addr_o`/`op_data_o` to that write. `mode_o` becomes 2 (program).
- R3: Unlock, then 0x80 at 0x555, then unlock again, then 0x30 at any address in sector S. This raises `erase_start_o` for one cycle with `op_sector_o` = S (the top SECT_BITS address bits). `mode_o` becomes 3 (erase).
- R4: While a program or erase runs, `op_done_i` returns the mode to read-array, or to erase-suspend for a program started during suspend. `op_fail_i` moves the mode to 5 (error) and takes priority over a simultaneous done.
- R5: Data 0xF0 at any address returns read-array mode from read-array, from a partial sequence, from autoselect and from error. A write that supplies program data is taken as data even if it equals 0xF0.
- R6: Unlock, then 0x90 at 0x555, enters mode 1 (autoselect), and reads return source 2 (identification). In autoselect and in error mode, every write other than 0xF0 is ignored.
- R7: A write that breaks the expected unlock or command order outside suspend enters error mode.
- R8: Data 0xB0 at any address during an erase enters mode 4 (suspend) and raises `erase_hold_o`. Reads in the suspended sector then return source 1 (status), and reads in other sectors return source 0. Data 0x30 at any address resumes the erase (mode 3, hold low).
- R9: During suspend, unlock and 0xA0 followed by a write outside the suspended sector starts a program (mode 2, hold stays high), and done returns to suspend with the same read rule. A program target inside the suspended sector, or a broken unlock, returns to suspend with no start.
- R10: A program or erase aimed at a sector whose `prot_map_i` bit is set, while `hv_unprot_i` is low, gives no start pulse and returns to read-array (or to suspend). With `hv_unprot_i` high the operation starts, and removing it restores the block.
- R11: In program, erase and error modes, every read returns source 1 (status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | One qualified write this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data, command byte in bits 7:0 |
| op_done_i | input | 1 | Embedded operation finished |
| op_fail_i | input | 1 | Embedded operation failed |
| prot_map_i | input | 2**SECT_BITS | Protect bit per sector |
| hv_unprot_i | input | 1 | High voltage on reset pin: protection lifted |
| rd_sect_i | input | SECT_BITS | Sector field of the current read address |
| mode_o | output | 3 | Operating mode code |
| rd_src_o | output | 2 | Read source: 0 array, 1 status, 2 identification |
| prog_start_o | output | 1 | Program start pulse |
| erase_start_o | output | 1 | Sector erase start pulse |
| erase_hold_o | output | 1 | Erase is suspended |
| op_addr_o | output | ADDR_W | Address of the started program |
| op_data_o | output | DATA_W | Data of the started program |
| op_sector_o | output | SECT_BITS | Sector of the started erase |

## Verification
The bench builds the block with a 12-bit address, 8-bit data and 2 sector bits. This gives four sectors, so every sector can be swept as a target. It programs and erases each sector under all four combinations of its protect bit and the high-voltage input. For each sector it also suspends an erase, reads all four sectors, and runs a program in a neighbouring sector and in the suspended one. The small sector count keeps these sweeps complete while the unlock addresses still lie in the low bits.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

  typedef enum logic [2:0] {
    M_READ    = 3'd0,
    M_AUTOSEL = 3'd1,
    M_PROG    = 3'd2,
    M_ERASE   = 3'd3,
    M_SUSP    = 3'd4,
    M_ERROR   = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_STATUS = 2'd1,
    RS_ID     = 2'd2
  } rdsrc_e;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PARG, S_PBUSY,
    S_ESET, S_EUNL1, S_EUNL2, S_EBUSY,
    S_SUSP, S_SUNL1, S_SUNL2, S_SPARG, S_SPBUSY,
    S_AUTO, S_ERR
  } state_e;

  localparam logic [10:0] KEY_ADDR_A = 11'h555;
  localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  OP_PROG    = 8'hA0;
  localparam logic [7:0]  OP_ESETUP  = 8'h80;
  localparam logic [7:0]  OP_IDENT   = 8'h90;
  localparam logic [7:0]  OP_RESET   = 8'hF0;
  localparam logic [7:0]  OP_SUSPEND = 8'hB0;
  localparam logic [7:0]  OP_RESUME  = 8'h30;
  localparam logic [7:0]  OP_SECTOR  = 8'h30;

  function automatic mode_e mode_of(state_e s);
    case (s)
      S_PBUSY, S_SPBUSY:                  return M_PROG;
      S_EBUSY:                            return M_ERASE;
      S_SUSP, S_SUNL1, S_SUNL2, S_SPARG:  return M_SUSP;
      S_AUTO:                             return M_AUTOSEL;
      S_ERR:                              return M_ERROR;
      default:                            return M_READ;
    endcase
  endfunction

  function automatic logic is_suspended(state_e s);
    return (s == S_SUSP) || (s == S_SUNL1) || (s == S_SUNL2) ||
           (s == S_SPARG) || (s == S_SPBUSY);
  endfunction

endpackage

// File: rtl/fcm_wr_decode.sv
module fcm_wr_decode
  import fcm_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 3,
  localparam int NSECT    = 1 << SECT_BITS
) (
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [NSECT-1:0]     prot_map,
  input  logic                 hv_unprot,
  output logic                 key_a,
  output logic                 key_b,
  output logic                 at_cmd,
  output logic [7:0]           cbyte,
  output logic [SECT_BITS-1:0] sector,
  output logic                 prot_hit
);

  logic [NSECT-1:0] eff_prot;
  logic [10:0]      low_addr;

  assign low_addr = wr_addr[10:0];
  assign cbyte    = wr_data[7:0];
  assign sector   = wr_addr[ADDR_W-1 -: SECT_BITS];
  assign at_cmd   = (low_addr == KEY_ADDR_A);
  assign key_a    = at_cmd && (cbyte == KEY_DATA_A);
  assign key_b    = (low_addr == KEY_ADDR_B) && (cbyte == KEY_DATA_B);

  for (genvar i = 0; i < NSECT; i++) begin : g_prot
    assign eff_prot[i] = prot_map[i] & ~hv_unprot;
  end

  assign prot_hit = eff_prot[sector];

endmodule

// File: rtl/fcm_seq.sv
module fcm_seq
  import fcm_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_valid,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 key_a,
  input  logic                 key_b,
  input  logic                 at_cmd,
  input  logic [7:0]           cbyte,
  input  logic [SECT_BITS-1:0] sector,
  input  logic                 prot_hit,
  input  logic                 op_done,
  input  logic                 op_fail,
  output state_e               st_q,
  output mode_e                mode_q,
  output logic [SECT_BITS-1:0] susp_sect_q,
  output logic                 prog_start_q,
  output logic                 erase_start_q,
  output logic                 erase_hold_q,
  output logic [ADDR_W-1:0]    op_addr_q,
  output logic [DATA_W-1:0]    op_data_q,
  output logic [SECT_BITS-1:0] op_sector_q
);

  state_e st_d;
  logic   pstart, estart, is_rst;

  assign is_rst = (cbyte == OP_RESET);

  always_comb begin
    st_d   = st_q;
    pstart = 1'b0;
    estart = 1'b0;
    case (st_q)
      S_READ, S_ESET: if (wr_valid)
        st_d = is_rst ? S_READ : key_a ? ((st_q == S_READ) ? S_UNL1 : S_EUNL1) : S_ERR;
      S_UNL1, S_EUNL1: if (wr_valid)
        st_d = is_rst ? S_READ : key_b ? ((st_q == S_UNL1) ? S_UNL2 : S_EUNL2) : S_ERR;
      S_UNL2: if (wr_valid) begin
        if (is_rst)                         st_d = S_READ;
        else if (at_cmd && cbyte == OP_PROG)   st_d = S_PARG;
        else if (at_cmd && cbyte == OP_ESETUP) st_d = S_ESET;
        else if (at_cmd && cbyte == OP_IDENT)  st_d = S_AUTO;
        else                                st_d = S_ERR;
      end
      S_PARG: if (wr_valid) begin
        if (prot_hit) st_d = S_READ;
        else begin st_d = S_PBUSY; pstart = 1'b1; end
      end
      S_PBUSY: begin
        if (op_fail)      st_d = S_ERR;
        else if (op_done) st_d = S_READ;
      end
      S_EUNL2: if (wr_valid) begin
        if (is_rst)                  st_d = S_READ;
        else if (cbyte == OP_SECTOR) begin
          if (prot_hit) st_d = S_READ;
          else begin st_d = S_EBUSY; estart = 1'b1; end
        end else                     st_d = S_ERR;
      end
      S_EBUSY: begin
        if (op_fail)                               st_d = S_ERR;
        else if (op_done)                          st_d = S_READ;
        else if (wr_valid && cbyte == OP_SUSPEND)  st_d = S_SUSP;
      end
      S_SUSP: if (wr_valid) begin
        if (cbyte == OP_RESUME) st_d = S_EBUSY;
        else if (key_a)         st_d = S_SUNL1;
      end
      S_SUNL1: if (wr_valid) st_d = key_b ? S_SUNL2 : S_SUSP;
      S_SUNL2: if (wr_valid) st_d = (at_cmd && cbyte == OP_PROG) ? S_SPARG : S_SUSP;
      S_SPARG: if (wr_valid) begin
        if (prot_hit || sector == susp_sect_q) st_d = S_SUSP;
        else begin st_d = S_SPBUSY; pstart = 1'b1; end
      end
      S_SPBUSY: begin
        if (op_fail)      st_d = S_ERR;
        else if (op_done) st_d = S_SUSP;
      end
      S_AUTO, S_ERR: if (wr_valid && is_rst) st_d = S_READ;
      default: st_d = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= S_READ;
      mode_q        <= M_READ;
      prog_start_q  <= 1'b0;
      erase_start_q <= 1'b0;
      erase_hold_q  <= 1'b0;
      susp_sect_q   <= '0;
      op_addr_q     <= '0;
      op_data_q     <= '0;
      op_sector_q   <= '0;
    end else begin
      st_q          <= st_d;
      mode_q        <= mode_of(st_d);
      prog_start_q  <= pstart;
      erase_start_q <= estart;
      erase_hold_q  <= is_suspended(st_d);
      if (pstart) begin
        op_addr_q <= wr_addr;
        op_data_q <= wr_data;
      end
      if (estart) begin
        op_sector_q <= sector;
        susp_sect_q <= sector;
      end
    end
  end

  a_r1_reset_read: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_q == M_READ && !prog_start_q && !erase_start_q));
  a_r2_one_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start_q, erase_start_q}));
  a_r4_done_read: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_PBUSY && op_done && !op_fail) |=> mode_q == M_READ);
  a_r4_fail_error: assert property (@(posedge clk) disable iff (rst)
    ((st_q == S_PBUSY || st_q == S_EBUSY || st_q == S_SPBUSY) && op_fail) |=> mode_q == M_ERROR);
  a_r6_auto_sticky: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_AUTO && !(wr_valid && is_rst)) |=> mode_q == M_AUTOSEL);
  a_r5_reset_cmd: assert property (@(posedge clk) disable iff (rst)
    ((st_q == S_AUTO || st_q == S_ERR) && wr_valid && is_rst) |=> mode_q == M_READ);
  a_r10_protect: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (st_q == S_PARG || st_q == S_SPARG) && prot_hit) |=> !prog_start_q);
  a_r8_hold_mode: assert property (@(posedge clk) disable iff (rst)
    erase_hold_q |-> (mode_q == M_SUSP || mode_q == M_PROG));

endmodule

// File: rtl/fcm_rd_steer.sv
module fcm_rd_steer
  import fcm_pkg::*;
#(
  parameter int SECT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  state_e               st,
  input  logic [SECT_BITS-1:0] susp_sect,
  input  logic [SECT_BITS-1:0] rd_sect,
  output rdsrc_e               rd_src_q
);

  rdsrc_e src_d;

  always_comb begin
    case (st)
      S_AUTO:                             src_d = RS_ID;
      S_PBUSY, S_EBUSY, S_SPBUSY, S_ERR:  src_d = RS_STATUS;
      S_SUSP, S_SUNL1, S_SUNL2, S_SPARG:  src_d = (rd_sect == susp_sect) ? RS_STATUS : RS_ARRAY;
      default:                            src_d = RS_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_src_q <= RS_ARRAY;
    else     rd_src_q <= src_d;
  end

  a_r11_busy_status: assert property (@(posedge clk) disable iff (rst)
    (st == S_ERR || st == S_PBUSY || st == S_EBUSY) |=> rd_src_q == RS_STATUS);
  a_r6_ident_src: assert property (@(posedge clk) disable iff (rst)
    (st == S_AUTO) |=> rd_src_q == RS_ID);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcm_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 3,
  localparam int NSECT    = 1 << SECT_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_valid_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 op_done_i,
  input  logic                 op_fail_i,
  input  logic [NSECT-1:0]     prot_map_i,
  input  logic                 hv_unprot_i,
  input  logic [SECT_BITS-1:0] rd_sect_i,
  output logic [2:0]           mode_o,
  output logic [1:0]           rd_src_o,
  output logic                 prog_start_o,
  output logic                 erase_start_o,
  output logic                 erase_hold_o,
  output logic [ADDR_W-1:0]    op_addr_o,
  output logic [DATA_W-1:0]    op_data_o,
  output logic [SECT_BITS-1:0] op_sector_o
);

  logic                 key_a, key_b, at_cmd, prot_hit;
  logic [7:0]           cbyte;
  logic [SECT_BITS-1:0] wr_sect, susp_sect;
  state_e               st;
  mode_e                mode;
  rdsrc_e               rd_src;

  fcm_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_dec (
    .wr_addr(wr_addr_i), .wr_data(wr_data_i), .prot_map(prot_map_i),
    .hv_unprot(hv_unprot_i), .key_a(key_a), .key_b(key_b), .at_cmd(at_cmd),
    .cbyte(cbyte), .sector(wr_sect), .prot_hit(prot_hit)
  );

  fcm_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_seq (
    .clk(clk), .rst(rst), .wr_valid(wr_valid_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .key_a(key_a), .key_b(key_b), .at_cmd(at_cmd),
    .cbyte(cbyte), .sector(wr_sect), .prot_hit(prot_hit),
    .op_done(op_done_i), .op_fail(op_fail_i), .st_q(st), .mode_q(mode),
    .susp_sect_q(susp_sect), .prog_start_q(prog_start_o),
    .erase_start_q(erase_start_o), .erase_hold_q(erase_hold_o),
    .op_addr_q(op_addr_o), .op_data_q(op_data_o), .op_sector_q(op_sector_o)
  );

  fcm_rd_steer #(.SECT_BITS(SECT_BITS)) u_rd (
    .clk(clk), .rst(rst), .st(st), .susp_sect(susp_sect),
    .rd_sect(rd_sect_i), .rd_src_q(rd_src)
  );

  assign mode_o   = mode;
  assign rd_src_o = rd_src;

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int AW = 12, DW = 8, SB = 2, NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          op_done = 1'b0, op_fail = 1'b0;
  logic [NS-1:0] prot_map = '0;
  logic          hv = 1'b0;
  logic [SB-1:0] rd_sect = '0;
  logic [2:0]    mode;
  logic [1:0]    rd_src;
  logic          pstart, estart, hold;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [SB-1:0] op_sect;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_BITS(SB)) u0 (
    .clk(clk), .rst(rst), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .op_done_i(op_done), .op_fail_i(op_fail),
    .prot_map_i(prot_map), .hv_unprot_i(hv), .rd_sect_i(rd_sect),
    .mode_o(mode), .rd_src_o(rd_src), .prog_start_o(pstart),
    .erase_start_o(estart), .erase_hold_o(hold), .op_addr_o(op_addr),
    .op_data_o(op_data), .op_sector_o(op_sect)
  );

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    unlock(); wr(12'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase(input int s);
    unlock(); wr(12'h555, 8'h80); unlock(); wr({s[1:0], 10'h0C4}, 8'h30);
  endtask

  task automatic rd(input int s);
    @(negedge clk); rd_sect = s[SB-1:0];
    @(negedge clk);
  endtask

  task automatic pulse(input bit d, input bit f);
    @(negedge clk); op_done = d; op_fail = f;
    @(negedge clk); op_done = 1'b0; op_fail = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 rd_src", rd_src, 0);
    chk("R1 starts", {pstart, estart, hold}, 0);

    // R2 program start and R10 protection sweep
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++) begin
          bit go;
          logic [AW-1:0] a;
          go = !(p == 1 && h == 0);
          prot_map = p ? (4'b1 << s) : 4'b0;
          hv = h[0];
          a = {s[1:0], 10'h0AB};
          prog(a, 8'(s * 16 + h));
          chk("R10 prog start", pstart, go);
          chk("R10 prog mode", mode, go ? 2 : 0);
          if (go) begin
            chk("R2 op_addr", op_addr, a);
            chk("R2 op_data", op_data, s * 16 + h);
            rd(s); chk("R11 prog status", rd_src, 1);
            pulse(1, 0); chk("R4 prog done", mode, 0);
          end
          erase(s);
          chk("R10 erase start", estart, go);
          chk("R10 erase mode", mode, go ? 3 : 0);
          if (go) begin
            chk("R3 op_sector", op_sect, s);
            pulse(1, 0); chk("R4 erase done", mode, 0);
          end
        end
    // R10 restoring protection after hv removed
    prot_map = 4'b0100; hv = 1'b1;
    prog({2'd2, 10'h011}, 8'h5A); chk("R10 hv start", pstart, 1); pulse(1, 0);
    hv = 1'b0;
    prog({2'd2, 10'h011}, 8'h5A); chk("R10 restored", pstart, 0);
    chk("R10 restored mode", mode, 0);
    prot_map = '0;

    // R8 and R9 suspend sweep
    for (int s = 0; s < NS; s++) begin
      int o;
      o = (s + 1) % NS;
      erase(s);
      wr(12'h7F3, 8'hB0);
      chk("R8 suspend mode", mode, 4);
      chk("R8 hold", hold, 1);
      for (int r = 0; r < NS; r++) begin
        rd(r); chk("R8 suspend read", rd_src, r == s ? 1 : 0);
      end
      prog({o[1:0], 10'h155}, 8'h3C);
      chk("R9 susp prog start", pstart, 1);
      chk("R9 susp prog mode", mode, 2);
      chk("R9 hold in prog", hold, 1);
      rd(o); chk("R11 susp prog status", rd_src, 1);
      pulse(1, 0);
      chk("R9 back to suspend", mode, 4);
      for (int r = 0; r < NS; r++) begin
        rd(r); chk("R9 suspend read after prog", rd_src, r == s ? 1 : 0);
      end
      prog({s[1:0], 10'h155}, 8'h3C);
      chk("R9 inside suspended no start", pstart, 0);
      chk("R9 inside suspended mode", mode, 4);
      wr(12'h555, 8'hAA); wr(12'h123, 8'h77);
      chk("R9 broken unlock", mode, 4);
      wr(12'h9E0, 8'h30);
      chk("R8 resume mode", mode, 3);
      chk("R8 resume hold", hold, 0);
      pulse(1, 0);
      chk("R4 erase done", mode, 0);
      rd(s); chk("R8 array after done", rd_src, 0);
    end

    // R4 fail, error stickiness, R5 reset
    prog(12'h321, 8'h11);
    pulse(0, 1); chk("R4 fail", mode, 5);
    rd(0); chk("R11 error status", rd_src, 1);
    wr(12'h555, 8'hAA); chk("R6 error ignores", mode, 5);
    wr(12'hBCD, 8'hF0); chk("R5 reset from error", mode, 0);
    erase(3);
    pulse(1, 1); chk("R4 fail beats done", mode, 5);
    wr(12'h000, 8'hF0); chk("R5 reset", mode, 0);

    // R6 autoselect
    unlock(); wr(12'h555, 8'h90);
    chk("R6 autoselect mode", mode, 1);
    rd(2); chk("R6 ident read", rd_src, 2);
    wr(12'h555, 8'hAA); chk("R6 auto ignores", mode, 1);
    wr(12'h2AA, 8'h30); chk("R6 auto ignores 30", mode, 1);
    wr(12'h456, 8'hF0); chk("R5 reset from auto", mode, 0);

    // R7 wrong order
    wr(12'h555, 8'h12); chk("R7 bad first", mode, 5);
    wr(12'h000, 8'hF0);
    wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); chk("R7 bad second addr", mode, 5);
    wr(12'h000, 8'hF0);
    unlock(); wr(12'h555, 8'h77); chk("R7 bad command", mode, 5);
    wr(12'h000, 8'hF0);
    unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'h55); chk("R7 bad erase unlock", mode, 5);
    wr(12'h000, 8'hF0);

    // R5 reset mid-sequence, then clean program; program data F0
    wr(12'h555, 8'hAA); wr(12'hABC, 8'hF0); chk("R5 mid-seq reset", mode, 0);
    prog(12'h0F0, 8'hF0);
    chk("R5 F0 as data start", pstart, 1);
    chk("R5 F0 as data value", op_data, 8'hF0);
    pulse(1, 0);
    chk("R1 final read mode", mode, 0);

    summary();
  end
endmodule